// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block turns two groups of asynchronous external pins into two interrupt request lines. Each group has its own two-bit trigger selection. Three of the selections respond to edges only: rising edges, falling edges, or both. The fourth raises a request on a falling edge and also keeps it raised for as long as any pin of the group is held low. One setting applies to all the pins of a group. A rising edge on any pin qualifies as a rising edge for that group, and a falling edge on any pin qualifies as a falling edge.

The trigger selections sit in an 8-bit control register together with four general-purpose bits. The selection fields can be changed only while the processor's global interrupt mask input is high, so an unmasked program cannot retune an interrupt source. The general-purpose bits are writable at all times.

Every pin passes through a two-flop synchroniser, and the block keeps the previous synchronised value to find edges. A request stays latched until software pulses the clear line for that group.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After synchronous reset the register reads 00h (both groups select falling-edge-plus-low-level mode) and both `irq_req` bits are 0.
- R2: With selection 01 (rising only), a low-to-high change on any pin of the group sets the group request. A high-to-low change does not set it.
- R3: With selection 10 (falling only), a high-to-low change on any pin of the group sets the group request. A low-to-high change does not set it.
- R4: With selection 11 (both edges), a change in either direction on any pin of the group sets the group request.
- R5: With selection 00, a falling edge sets the request. The request stays 1 while any pin of the group is low, even across a clear pulse. Once all pins are high, it stays 1 until a clear pulse arrives. A rising edge alone never sets it.
- R6: In every mode the edge-triggered part of the request is sticky. A clear pulse on `req_clr[g]` drops it on the next clock edge. A clear in the same cycle as a qualifying edge leaves the request set.
- R7: Register bits 7:6 and 4:3 (the selection fields) take a write only when `int_mask` is 1. Otherwise they keep their value.
- R8: Register bits 5 and 2:0 take every write, whatever the value of `int_mask`.
- R9: Bits 7:6 select the mode of group 0 (`pins_g0`, request bit 0). Bits 4:3 select the mode of group 1 (`pins_g1`, request bit 1). Activity on one group never changes the other group's request.
- R10: A pin change that is stable before clock edge 1 shows on `irq_req` just after edge 3, and not earlier. A clear sampled on an edge takes effect at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Register write data |
| int_mask | input | 1 | Global interrupt mask from the processor; 1 = masked, selection fields writable |
| pins_g0 | input | GRP0_PINS | External pins of group 0 |
| pins_g1 | input | GRP1_PINS | External pins of group 1 |
| req_clr | input | 2 | Per-group request clear pulse (bit g clears group g) |
| cfg_rd_data | output | 8 | Current register contents |
| irq_req | output | 2 | Per-group interrupt request |

## Verification
A wrong selection field shows up directly on `cfg_rd_data` one cycle after the write. A selection that does not match the intended mode shows up three cycles after the first pin edge, when `irq_req` rises where it should stay quiet or stays quiet where it should rise. A stuck or lost sticky flag appears on `irq_req` one cycle after a clear. A wrong level-hold term appears after a clear while a pin is still low. The synchroniser depth is checked by sampling the request both before and after the third edge.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int CFG_W = 8;
  // bits of the register that ignore the interrupt mask
  localparam logic [CFG_W-1:0] FREE_BITS = 8'h27;
  localparam int G0_LSB = 6;
  localparam int G1_LSB = 3;

  typedef enum logic [1:0] {
    SENSE_FALL_LOW = 2'b00,
    SENSE_RISE     = 2'b01,
    SENSE_FALL     = 2'b10,
    SENSE_BOTH     = 2'b11
  } sense_e;
endpackage

// File: rtl/extint_cfg_reg.sv
module extint_cfg_reg
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             mask_set,
  output logic [CFG_W-1:0] cfg_q,
  output sense_e           mode_g0,
  output sense_e           mode_g1
);
  logic [CFG_W-1:0] prot_src;

  assign prot_src = mask_set ? wr_data : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= (wr_data & FREE_BITS) | (prot_src & ~FREE_BITS);
    end
  end

  assign mode_g0 = sense_e'(cfg_q[G0_LSB +: 2]);
  assign mode_g1 = sense_e'(cfg_q[G1_LSB +: 2]);

  p_fields_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mask_set) |=> ($stable(cfg_q[7:6]) && $stable(cfg_q[4:3])));

  p_free_bits_written_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cfg_q[5] == $past(wr_data[5]) && cfg_q[2:0] == $past(wr_data[2:0])));
endmodule

// File: rtl/extint_pin_sync.sv
module extint_pin_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;

  // reset to ones: pins are taken to idle high, so no edge appears on reset exit
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '1;
      cur    <= '1;
      prev   <= '1;
    end else begin
      meta_q <= pins;
      cur    <= meta_q;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/extint_group_det.sv
module extint_group_det
  import extint_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  sense_e       mode,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic         clr,
  output logic         req
);
  logic any_rise, any_fall, any_low, evt, level_hit;
  logic flag_q, flag_nxt;

  assign any_rise = |(cur & ~prev);
  assign any_fall = |(~cur & prev);
  assign any_low  = ~(&cur);

  always_comb begin
    unique case (mode)
      SENSE_RISE: evt = any_rise;
      SENSE_FALL: evt = any_fall;
      SENSE_BOTH: evt = any_rise | any_fall;
      default:    evt = any_fall;
    endcase
  end

  assign level_hit = (mode == SENSE_FALL_LOW) && any_low;
  // a fresh edge wins over a clear in the same cycle
  assign flag_nxt  = evt | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      req    <= flag_nxt | level_hit;
    end
  end

  p_edge_sets_req_r6: assert property (@(posedge clk) disable iff (rst)
    evt |=> req);

  p_low_holds_req_r5: assert property (@(posedge clk) disable iff (rst)
    ((mode == SENSE_FALL_LOW) && any_low) |=> req);

  p_clear_drops_req_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && !evt && mode != SENSE_FALL_LOW) |=> !req);
endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
  import extint_pkg::*;
#(
  parameter int GRP0_PINS = 4,
  parameter int GRP1_PINS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr_en,
  input  logic [7:0]           cfg_wr_data,
  input  logic                 int_mask,
  input  logic [GRP0_PINS-1:0] pins_g0,
  input  logic [GRP1_PINS-1:0] pins_g1,
  input  logic [1:0]           req_clr,
  output logic [7:0]           cfg_rd_data,
  output logic [1:0]           irq_req
);
  sense_e mode_g0, mode_g1;
  logic [GRP0_PINS-1:0] cur0, prev0;
  logic [GRP1_PINS-1:0] cur1, prev1;

  extint_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .mask_set(int_mask), .cfg_q(cfg_rd_data),
    .mode_g0(mode_g0), .mode_g1(mode_g1)
  );

  extint_pin_sync #(.W(GRP0_PINS)) u_sync0 (
    .clk(clk), .rst(rst), .pins(pins_g0), .cur(cur0), .prev(prev0)
  );

  extint_pin_sync #(.W(GRP1_PINS)) u_sync1 (
    .clk(clk), .rst(rst), .pins(pins_g1), .cur(cur1), .prev(prev1)
  );

  extint_group_det #(.W(GRP0_PINS)) u_det0 (
    .clk(clk), .rst(rst), .mode(mode_g0), .cur(cur0), .prev(prev0),
    .clr(req_clr[0]), .req(irq_req[0])
  );

  extint_group_det #(.W(GRP1_PINS)) u_det1 (
    .clk(clk), .rst(rst), .mode(mode_g1), .cur(cur1), .prev(prev1),
    .clr(req_clr[1]), .req(irq_req[1])
  );

  p_reg_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!cfg_wr_en) |=> $stable(cfg_rd_data));
endmodule

// File: tb/extint_sense_ctrl_tb_top.sv
`timescale 1ns/1ps
module extint_sense_ctrl_tb_top;
  localparam int P0 = 4;
  localparam int P1 = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic int_mask = 1'b0;
  logic [P0-1:0] pins_g0 = '1;
  logic [P1-1:0] pins_g1 = '1;
  logic [1:0] req_clr = '0;
  logic [7:0] cfg_rd_data;
  logic [1:0] irq_req;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  extint_sense_ctrl #(.GRP0_PINS(P0), .GRP1_PINS(P1)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .int_mask(int_mask), .pins_g0(pins_g0), .pins_g1(pins_g1),
    .req_clr(req_clr), .cfg_rd_data(cfg_rd_data), .irq_req(irq_req)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pins_g0 = '1; pins_g1 = '1; req_clr = '0; cfg_wr_en = 1'b0;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic m);
    cfg_wr_en = 1'b1; cfg_wr_data = d; int_mask = m;
    cyc(1);
    cfg_wr_en = 1'b0; int_mask = 1'b0;
  endtask

  task automatic clr(input logic [1:0] c);
    req_clr = c;
    cyc(1);
    req_clr = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reg", cfg_rd_data, 8'h00);
    chk("R1 req", {6'b0, irq_req}, 8'h00);
  endtask

  task automatic t_protect();
    do_reset();
    wr(8'hFF, 1'b0);
    chk("R7/R8 unmasked write", cfg_rd_data, 8'h27);
    wr(8'hFF, 1'b1);
    chk("R7 masked write", cfg_rd_data, 8'hFF);
    wr(8'h00, 1'b0);
    chk("R7/R8 unmasked clear", cfg_rd_data, 8'hD8);
    wr(8'h00, 1'b1);
    chk("R7 masked clear", cfg_rd_data, 8'h00);
  endtask

  task automatic t_rise();
    do_reset();
    wr(8'h40, 1'b1);
    pins_g0[1] = 1'b0; cyc(3);
    chk("R2 falling ignored", {6'b0, irq_req}, 8'h00);
    pins_g0[1] = 1'b1; cyc(2);
    chk("R10 not yet", {6'b0, irq_req}, 8'h00);
    cyc(1);
    chk("R2/R10 rise sets", {6'b0, irq_req}, 8'h01);
    cyc(4);
    chk("R6 sticky", {6'b0, irq_req}, 8'h01);
    clr(2'b01);
    chk("R6 clear", {6'b0, irq_req}, 8'h00);
  endtask

  task automatic t_fall();
    do_reset();
    wr(8'h10, 1'b1);
    pins_g1[2] = 1'b0; cyc(3);
    chk("R3 fall sets", {6'b0, irq_req}, 8'h02);
    clr(2'b10);
    chk("R3 clear", {6'b0, irq_req}, 8'h00);
    pins_g1[2] = 1'b1; cyc(3);
    chk("R3 rising ignored", {6'b0, irq_req}, 8'h00);
  endtask

  task automatic t_both();
    do_reset();
    wr(8'hC0, 1'b1);
    pins_g0[3] = 1'b0; cyc(3);
    chk("R4 fall sets", {6'b0, irq_req}, 8'h01);
    clr(2'b01);
    pins_g0[3] = 1'b1; cyc(3);
    chk("R4 rise sets", {6'b0, irq_req}, 8'h01);
  endtask

  task automatic t_fall_low();
    do_reset();
    pins_g0[0] = 1'b0; cyc(3);
    chk("R5 fall sets", {6'b0, irq_req}, 8'h01);
    clr(2'b01);
    chk("R5 low holds past clear", {6'b0, irq_req}, 8'h01);
    pins_g0[0] = 1'b1; cyc(3);
    chk("R5 drops when high after clear", {6'b0, irq_req}, 8'h00);
    pins_g0[2] = 1'b0; cyc(3);
    pins_g0[2] = 1'b1; cyc(3);
    chk("R5 flag held after pin high", {6'b0, irq_req}, 8'h01);
    clr(2'b01);
    chk("R5 clear drops", {6'b0, irq_req}, 8'h00);
  endtask

  task automatic t_race();
    do_reset();
    wr(8'h40, 1'b1);
    pins_g0[0] = 1'b0; cyc(3);
    pins_g0[0] = 1'b1; cyc(3);
    chk("R6 set before race", {6'b0, irq_req}, 8'h01);
    pins_g0[0] = 1'b0; cyc(3);
    pins_g0[0] = 1'b1; cyc(2);
    clr(2'b01);
    chk("R6 clear with edge keeps set", {6'b0, irq_req}, 8'h01);
    clr(2'b01);
    chk("R6 later clear drops", {6'b0, irq_req}, 8'h00);
  endtask

  task automatic t_groups();
    do_reset();
    wr(8'h50, 1'b1);
    chk("R9 fields", cfg_rd_data, 8'h50);
    pins_g1[1] = 1'b0; pins_g0[2] = 1'b0; cyc(3);
    chk("R9 group1 fall only", {6'b0, irq_req}, 8'h02);
    clr(2'b10);
    pins_g1[1] = 1'b1; cyc(3);
    chk("R9 group1 rise ignored", {6'b0, irq_req}, 8'h00);
    pins_g0[2] = 1'b1; cyc(3);
    chk("R9 group0 rise only", {6'b0, irq_req}, 8'h01);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    t_reset();
    t_protect();
    t_rise();
    t_fall();
    t_both();
    t_fall_low();
    t_race();
    t_groups();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule